// File: doc/BRIEF.md
# Write Protection Violation Monitor

This block sits beside the configuration registers of a serial-peripheral controller and watches every register-bus write. When write protection is on, it raises a combinational block signal for writes aimed at the mode register or any chip-select configuration register. The register file uses that signal to suppress the write.

The block keeps three independent sticky violation flags:
- a write that protection blocked;
- a software reset issued while protection was on;
- a reconfiguration write that landed while the affected chip select was active.

It also keeps the bus offset of the most recent offending register write. Software reads all of this through one read-only status word at offset 0xE8. The read clears the flags and the stored offset.

The reset flag has an extra clearing path: a write to any of the main configuration registers also clears it. Each cause therefore clears under its own rule.

Top module: `wp_viol_monitor`

## Requirements
- R1: After asynchronous reset, a status read at 0xE8 returns 0x00000000.
- R2: `wr_block_o` is high in the same cycle as a write to the mode register (0x04) or a chip-select register (0x30, 0x34, 0x38, 0x3C) while `wp_en_i` is high. It is low for every other offset and whenever protection is off.
- R3: A blocked write sets status bit 0 from the next cycle on.
- R4: A software-reset strobe sets status bit 1 only if protection is enabled in the same cycle.
- R5: Status bit 2 is set by either of two writes, whether or not protection is on:
  - a write to the mode register while any chip select is active;
  - a write to chip-select register i (offset 0x30+4*i) while chip select i is active.
  A write to register i while only other chip selects are active leaves bit 2 unchanged.
- R6: Status word layout:
  - During a read of 0xE8, `rd_data_o` carries the source offset in bits 15:8 and the flags in bits 2:0, and all other bits are 0.
  - At any other time `rd_data_o` is 0.
  - A read at any other offset changes no state.
- R7: A read of 0xE8 clears all three flags and the source field at the following edge.
- R8: A write to 0x04, 0x14, 0x18 or 0x30..0x3C clears status bit 1, whether or not the write is blocked. Writes to other offsets leave bit 1 unchanged.
- R9: The source field takes the offset of the most recent write that set bit 0 or bit 2.
- R10: A violation in the same cycle as a status read remains set after the read.
- R11: A protected software reset in the same cycle as a bit-1-clearing write leaves bit 1 set.
- R12: Writes to 0xE8 have no effect on the status contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register-bus write strobe |
| wr_addr_i | input | 8 | Write offset |
| rd_en_i | input | 1 | Register-bus read strobe |
| rd_addr_i | input | 8 | Read offset |
| wp_en_i | input | 1 | Write protection enabled |
| swrst_i | input | 1 | Software-reset strobe |
| cs_active_i | input | 4 | Per-chip-select active vector |
| rd_data_o | output | 32 | Status read data |
| wr_block_o | output | 1 | Suppress the current write |

## Verification
The assertions check the following on every cycle:
- the block signal only appears when a write and protection are both present;
- blocked writes and protected resets always leave their flags set on the next cycle;
- a read with no competing event empties the register;
- reserved bits and idle read data stay zero.

Only the bench's scenarios can show which cases set which flags:
- chip-select index matching, versus activity on another select;
- the precedence of a new event over a clearing read or clearing write;
- which offset wins when violations follow one another;
- that a read at another offset, or a write to the status offset, leaves everything unchanged.

// File: rtl/wpvm_pkg.sv
package wpvm_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int NUM_CS    = 4;
  localparam int NUM_CAUSE = 3;
  localparam int MR_OFF    = 'h04;
  localparam int IER_OFF   = 'h14;
  localparam int IDR_OFF   = 'h18;
  localparam int CSR_BASE  = 'h30;
  localparam int STAT_OFF  = 'hE8;
  localparam int SRC_LSB   = 8;

  typedef enum logic [1:0] {
    CAUSE_BLOCK = 2'd0,
    CAUSE_SWRST = 2'd1,
    CAUSE_CSWR  = 2'd2
  } cause_e;
endpackage

// File: rtl/wpvm_decode.sv
module wpvm_decode #(
  parameter int ADDR_W   = wpvm_pkg::ADDR_W,
  parameter int NUM_CS   = wpvm_pkg::NUM_CS,
  parameter int MR_OFF   = wpvm_pkg::MR_OFF,
  parameter int IER_OFF  = wpvm_pkg::IER_OFF,
  parameter int IDR_OFF  = wpvm_pkg::IDR_OFF,
  parameter int CSR_BASE = wpvm_pkg::CSR_BASE
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_mr_o,
  output logic [NUM_CS-1:0] csr_sel_o,
  output logic              is_prot_o,
  output logic              is_cfg_o
);
  localparam logic [ADDR_W-1:0] MR_A  = ADDR_W'(MR_OFF);
  localparam logic [ADDR_W-1:0] IER_A = ADDR_W'(IER_OFF);
  localparam logic [ADDR_W-1:0] IDR_A = ADDR_W'(IDR_OFF);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csr
    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_BASE + 4 * i);
    assign csr_sel_o[i] = (addr_i == CSR_A);
  end

  assign is_mr_o   = (addr_i == MR_A);
  assign is_prot_o = is_mr_o | (|csr_sel_o);
  assign is_cfg_o  = is_prot_o | (addr_i == IER_A) | (addr_i == IDR_A);
endmodule

// File: rtl/wpvm_sticky.sv
module wpvm_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/wpvm_src.sv
module wpvm_src #(
  parameter int ADDR_W = wpvm_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     src_o <= '0;
    else if (load_i) src_o <= addr_i;
    else if (clr_i)  src_o <= '0;
  end
endmodule

// File: rtl/wp_viol_monitor.sv
module wp_viol_monitor #(
  parameter int ADDR_W    = wpvm_pkg::ADDR_W,
  parameter int DATA_W    = wpvm_pkg::DATA_W,
  parameter int NUM_CS    = wpvm_pkg::NUM_CS,
  parameter int STAT_OFF  = wpvm_pkg::STAT_OFF,
  parameter int SRC_LSB   = wpvm_pkg::SRC_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wp_en_i,
  input  logic              swrst_i,
  input  logic [NUM_CS-1:0] cs_active_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_block_o
);
  import wpvm_pkg::*;
  localparam int NC = NUM_CAUSE;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

  logic              is_mr, is_prot, is_cfg, cs_hit, rd_hit, src_load;
  logic [NUM_CS-1:0] csr_sel;
  logic [NC-1:0]     set_v, clr_v, flags_q;
  logic [ADDR_W-1:0] src_q;

  wpvm_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) i_decode (
    .addr_i    (wr_addr_i),
    .is_mr_o   (is_mr),
    .csr_sel_o (csr_sel),
    .is_prot_o (is_prot),
    .is_cfg_o  (is_cfg)
  );

  assign wr_block_o = wr_en_i & wp_en_i & is_prot;
  assign cs_hit     = (is_mr & (|cs_active_i)) | (|(csr_sel & cs_active_i));
  assign rd_hit     = rd_en_i & (rd_addr_i == STAT_A);

  always_comb begin
    set_v              = '0;
    set_v[CAUSE_BLOCK] = wr_block_o;
    set_v[CAUSE_SWRST] = swrst_i & wp_en_i;
    set_v[CAUSE_CSWR]  = wr_en_i & cs_hit;
    clr_v              = {NC{rd_hit}};
    clr_v[CAUSE_SWRST] = rd_hit | (wr_en_i & is_cfg);
  end

  for (genvar c = 0; c < NC; c++) begin : g_flag
    wpvm_sticky i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[c]),
      .clr_i  (clr_v[c]),
      .q_o    (flags_q[c])
    );
  end

  assign src_load = set_v[CAUSE_BLOCK] | set_v[CAUSE_CSWR];

  wpvm_src #(.ADDR_W(ADDR_W)) i_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (src_load),
    .clr_i  (rd_hit),
    .addr_i (wr_addr_i),
    .src_o  (src_q)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_hit) begin
      rd_data_o[NC-1:0]                 = flags_q;
      rd_data_o[SRC_LSB +: ADDR_W]      = src_q;
    end
  end
endmodule

// File: rtl/wpvm_checker.sv
module wpvm_checker #(
  parameter int ADDR_W   = wpvm_pkg::ADDR_W,
  parameter int DATA_W   = wpvm_pkg::DATA_W,
  parameter int NC       = wpvm_pkg::NUM_CAUSE,
  parameter int STAT_OFF = wpvm_pkg::STAT_OFF,
  parameter int SRC_LSB  = wpvm_pkg::SRC_LSB
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              wp_en_i,
  input logic              swrst_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wr_block_o,
  input logic [NC-1:0]     flags_q,
  input logic [ADDR_W-1:0] src_q
);
  localparam int SRC_HI = SRC_LSB + ADDR_W;
  logic rd_hit;
  assign rd_hit = rd_en_i && (rd_addr_i == ADDR_W'(STAT_OFF));

  p_block_cond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_o |-> (wr_en_i && wp_en_i));

  p_block_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_o |=> flags_q[0]);

  p_swrst_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swrst_i && wp_en_i) |=> flags_q[1]);

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !wr_en_i && !swrst_i) |=> (flags_q == '0 && src_q == '0));

  p_block_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[0] && !rd_hit) |=> flags_q[0]);

  p_reserved_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[DATA_W-1:SRC_HI] == '0) && (rd_data_o[SRC_LSB-1:NC] == '0));

  p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> (rd_data_o == '0));
endmodule

bind wp_viol_monitor wpvm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFF(STAT_OFF), .SRC_LSB(SRC_LSB)
) i_wpvm_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .wp_en_i    (wp_en_i),
  .swrst_i    (swrst_i),
  .rd_data_o  (rd_data_o),
  .wr_block_o (wr_block_o),
  .flags_q    (flags_q),
  .src_q      (src_q)
);

// File: tb/test_wp_viol_monitor.sv
module test_wp_viol_monitor;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, wp_en = 1'b0, swrst = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [3:0]  cs_act = '0;
  logic [31:0] rd_data;
  logic        wr_block;

  int checks = 0, failures = 0;
  int m_flags = 0, m_src = 0;   // reference model state

  always #(CLK_P / 2) clk = ~clk;

  wp_viol_monitor i_wp_viol_monitor (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .wp_en_i(wp_en), .swrst_i(swrst),
    .cs_active_i(cs_act), .rd_data_o(rd_data), .wr_block_o(wr_block)
  );

  function automatic bit m_prot(int a);
    return a == 'h04 || a == 'h30 || a == 'h34 || a == 'h38 || a == 'h3C;
  endfunction

  function automatic bit m_cfg(int a);
    return m_prot(a) || a == 'h14 || a == 'h18;
  endfunction

  function automatic bit m_csviol(int a, logic [3:0] cs);
    if (a == 'h04) return cs != 0;
    for (int i = 0; i < 4; i++) if (a == 'h30 + 4 * i) return cs[i];
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive, compare outputs, clock the model
  task automatic step(string tag, bit w, int wa, bit r, int ra, bit wp, bit sr, logic [3:0] cs);
    int e_blk, e_rd, nf;
    bit rdh, s0, s1, s2;
    @(negedge clk);
    wr_en = w; wr_addr = 8'(wa); rd_en = r; rd_addr = 8'(ra);
    wp_en = wp; swrst = sr; cs_act = cs;
    #1;
    rdh   = r && ra == 'hE8;
    e_blk = (w && wp && m_prot(wa)) ? 1 : 0;
    e_rd  = rdh ? ((m_src << 8) | m_flags) : 0;
    check(tag, int'(wr_block), e_blk, "wr_block");
    check(tag, int'(rd_data), e_rd, "rd_data");
    @(posedge clk);
    s0 = e_blk != 0;
    s1 = sr && wp;
    s2 = w && m_csviol(wa, cs);
    nf = m_flags;
    if (rdh) nf = 0;
    if (w && m_cfg(wa)) nf = nf & ~2;
    if (s0) nf = nf | 1;
    if (s1) nf = nf | 2;
    if (s2) nf = nf | 4;
    m_flags = nf;
    if (s0 || s2) m_src = wa;
    else if (rdh) m_src = 0;
  endtask

  task automatic rd(string tag);
    step(tag, 0, 0, 1, 'hE8, 0, 0, 4'b0000);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1");
    // R2 decode and gating
    step("R2", 1, 'h10, 0, 0, 1, 0, 4'b0000);
    step("R2", 1, 'h40, 0, 0, 1, 0, 4'b0000);
    step("R2", 1, 'h3C, 0, 0, 0, 0, 4'b0000);
    rd("R2");
    step("R2", 1, 'h04, 0, 0, 1, 0, 4'b0000);
    // R6 other-offset read leaves state
    step("R6", 0, 0, 1, 'h10, 0, 0, 4'b0000);
    rd("R6");
    // R3 then R7
    step("R3", 1, 'h34, 0, 0, 1, 0, 4'b0000);
    rd("R3");
    rd("R7");
    // R4
    step("R4", 0, 0, 0, 0, 0, 1, 4'b0000);
    rd("R4");
    step("R4", 0, 0, 0, 0, 1, 1, 4'b0000);
    rd("R4");
    // R8 clearing writes
    step("R8", 0, 0, 0, 0, 1, 1, 4'b0000);
    step("R8", 1, 'h14, 0, 0, 1, 0, 4'b0000);
    rd("R8");
    step("R8", 0, 0, 0, 0, 1, 1, 4'b0000);
    step("R8", 1, 'h20, 0, 0, 1, 0, 4'b0000);
    rd("R8");
    step("R8", 0, 0, 0, 0, 1, 1, 4'b0000);
    step("R8", 1, 'h30, 0, 0, 0, 0, 4'b0000);
    rd("R8");
    // R5 chip-select index matching
    step("R5", 1, 'h38, 0, 0, 0, 0, 4'b0100);
    rd("R5");
    step("R5", 1, 'h38, 0, 0, 0, 0, 4'b1011);
    rd("R5");
    step("R5", 1, 'h04, 0, 0, 0, 0, 4'b1000);
    rd("R5");
    // R9 most recent offset wins
    step("R9", 1, 'h30, 0, 0, 1, 0, 4'b0000);
    step("R9", 1, 'h3C, 0, 0, 0, 0, 4'b1000);
    rd("R9");
    // R10 set during read
    step("R10", 1, 'h04, 1, 'hE8, 1, 0, 4'b0000);
    rd("R10");
    step("R10", 0, 0, 1, 'hE8, 1, 1, 4'b0000);
    rd("R10");
    // R11 protected reset vs clearing write
    step("R11", 1, 'h18, 0, 0, 1, 1, 4'b0000);
    rd("R11");
    // all three causes
    step("R5", 0, 0, 0, 0, 1, 1, 4'b0000);
    step("R5", 1, 'h34, 0, 0, 1, 0, 4'b0010);
    rd("R5");
    // R12 status offset is read-only
    step("R12", 1, 'h3C, 0, 0, 1, 0, 4'b0000);
    step("R12", 1, 'hE8, 0, 0, 1, 0, 4'b1111);
    rd("R12");
    rd("R12");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule